// File: doc/BRIEF.md
# Stereo Audio Transmit Sample Buffer

This block holds audio samples between a 32-bit write port and a serial audio shifter. Each write word is unpacked according to a channel mode into one or two sample slots. Dual stereo writes carry one sample each, alternating left and right. The compact 16-bit, compact 8-bit and mono modes carry a whole left/right pair per write. The buffer has 16 slots and its fill level is counted in slots, so a complete pair always counts as two. An odd level therefore means a left sample is waiting for its right partner.

The serializer pulls one complete pair per frame strobe. A strobe that finds fewer than two slots sets a sticky underrun flag. A service request output stays high while the level is below a programmable limit. A synchronous flush empties the buffer and restarts the left/right write phase.

Top module: `stx_tx_fifo`

## Requirements
- R1: The buffer holds at most 16 slots. A write is accepted (`wr_ok_o` high) only when the slots it needs fit: level + 1 ≤ 16 for a dual write, level + 2 ≤ 16 for any other mode. A rejected write leaves the level and the stored data unchanged.
- R2: With `mode_i` = 0 (dual stereo) each accepted write stores `wr_data_i` as one sample and adds 1 to the level. Writes alternate left, right, starting with left. `next_right_o` is high when the next dual write is a right sample. `mismatch_o` is high whenever the level is odd.
- R3: With `mode_i` = 1 (compact 16-bit) bits 15:0 form the left sample and bits 31:16 form the right sample. Both are zero-extended to 32 bits, and the level rises by 2.
- R4: With `mode_i` = 2 (compact 8-bit) bits 7:0 form the left sample and bits 15:8 form the right sample. Both are zero-extended, bits 31:16 have no effect, and the level rises by 2.
- R5: With `mode_i` = 3 (mono) the whole word is stored as both the left and the right sample, and the level rises by 2.
- R6: `req_o` is high exactly while the level is below the stored limit. A limit of 0 never requests, and a limit of 16 requests whenever any slot is free.
- R7: A pulse on `lim_we_i` loads `lim_val_i` into the limit. Values above 16 are stored as 16. The limit is 0 after reset and a flush keeps it.
- R8: A `pop_i` strobe with level ≥ 2 removes the oldest two slots in write order. They appear on `pair_left_o` and `pair_right_o`, with `pair_valid_o` high for exactly one cycle, after the next clock edge. The level drops by 2.
- R9: A `pop_i` strobe with level < 2 removes nothing and leaves `pair_valid_o` low. It sets `underflow_o`, which stays set until a flush or a reset.
- R10: `empty_o` is high whenever the level is below 2 (no full pair is stored).
- R11: `flush_i` clears the level, the write phase and `underflow_o` at the next edge. In that same cycle it overrides any write (`wr_ok_o` low) and any pop (no valid pair).
- R12: A write and a pop in the same cycle are each judged against the level before that edge. The popped pair comes only from slots already stored, and the new level is old level + written slots − popped slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Synchronous buffer clear |
| mode_i | input | 2 | Channel mode: 0 dual, 1 compact 16, 2 compact 8, 3 mono |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write word |
| wr_ok_o | output | 1 | Write accepted this cycle |
| lim_we_i | input | 1 | Limit load strobe |
| lim_val_i | input | 5 | New limit value |
| pop_i | input | 1 | Frame strobe from the serializer |
| pair_left_o | output | 32 | Popped left sample |
| pair_right_o | output | 32 | Popped right sample |
| pair_valid_o | output | 1 | Popped pair valid (one cycle) |
| empty_o | output | 1 | Fewer than two slots stored |
| level_o | output | 5 | Occupied slots |
| mismatch_o | output | 1 | Level is odd |
| next_right_o | output | 1 | Next dual write is a right sample |
| req_o | output | 1 | Service request |
| underflow_o | output | 1 | Sticky underrun flag |

## Verification
`wr_ok_o` is combinational, so the bench samples it 1 ns after it drives inputs on a falling edge. The level, phase, flags and request all change at the rising edge that takes the strobe. A popped pair with its valid flag also appears at that edge and lasts one cycle. The bench therefore checks all of these at the following falling edge, against a slot queue and a level counter it keeps itself. The limit sweep walks every limit from 0 to 20 against every level from 0 to 16, so the clamp and both limit extremes are covered.

// File: rtl/stx_pkg.sv
package stx_pkg;

    localparam int SMP_W   = 32;
    localparam int HALF_W  = 16;
    localparam int BYTE_W  = 8;

    typedef enum logic [1:0] {
        MODE_DUAL   = 2'd0,
        MODE_PACK16 = 2'd1,
        MODE_PACK8  = 2'd2,
        MODE_MONO   = 2'd3
    } chan_mode_e;

    // One write word after unpacking: one or two slots.
    typedef struct packed {
        logic [SMP_W-1:0] first;
        logic [SMP_W-1:0] second;
        logic             two;
    } slot_pair_t;

    function automatic slot_pair_t unpack_word(chan_mode_e m, logic [SMP_W-1:0] w);
        slot_pair_t p;
        p.first  = '0;
        p.second = '0;
        p.two    = 1'b1;
        unique case (m)
            MODE_DUAL: begin
                p.first = w;
                p.two   = 1'b0;
            end
            MODE_PACK16: begin
                p.first[HALF_W-1:0]  = w[HALF_W-1:0];
                p.second[HALF_W-1:0] = w[2*HALF_W-1:HALF_W];
            end
            MODE_PACK8: begin
                p.first[BYTE_W-1:0]  = w[BYTE_W-1:0];
                p.second[BYTE_W-1:0] = w[2*BYTE_W-1:BYTE_W];
            end
            default: begin
                p.first  = w;
                p.second = w;
            end
        endcase
        return p;
    endfunction

    // Ring index advance for a buffer of arbitrary depth.
    function automatic int unsigned ring_add(int unsigned p, int unsigned k, int unsigned depth);
        int unsigned s;
        s = p + k;
        if (s >= depth) s = s - depth;
        return s;
    endfunction

endpackage

// File: rtl/stx_unpack.sv
module stx_unpack
    import stx_pkg::*;
(
    input  logic [1:0]       mode_i,
    input  logic [SMP_W-1:0] word_i,
    output slot_pair_t       pair_o,
    output logic             is_dual_o
);
    chan_mode_e mode;

    always_comb begin
        mode      = chan_mode_e'(mode_i);
        pair_o    = unpack_word(mode, word_i);
        is_dual_o = (mode == MODE_DUAL);
    end
endmodule

// File: rtl/stx_level_ctl.sv
module stx_level_ctl
    import stx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic             wr_req_i,
    input  logic             wr_two_i,
    input  logic             wr_dual_i,
    input  logic             rd_req_i,
    input  logic             lim_we_i,
    input  logic [$clog2(DEPTH+1)-1:0] lim_val_i,
    output logic             wr_go_o,
    output logic             rd_go_o,
    output logic [$clog2(DEPTH)-1:0]   wr_ptr_o,
    output logic [$clog2(DEPTH)-1:0]   rd_ptr_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic             next_right_o,
    output logic             underflow_o,
    output logic             req_o,
    output logic             empty_o
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam int PTR_W = $clog2(DEPTH);

    logic [LVL_W-1:0] level_q, lim_q;
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic             right_q, uf_q;
    int unsigned      need, wadd, radd;

    always_comb begin
        need    = wr_two_i ? 2 : 1;
        wr_go_o = wr_req_i && !flush_i && (int'(level_q) + int'(need) <= DEPTH);
        rd_go_o = rd_req_i && !flush_i && (int'(level_q) >= 2);
        wadd    = wr_go_o ? need : 0;
        radd    = rd_go_o ? 2 : 0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            right_q  <= 1'b0;
            uf_q     <= 1'b0;
        end else if (flush_i) begin
            level_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            right_q  <= 1'b0;
            uf_q     <= 1'b0;
        end else begin
            level_q  <= LVL_W'(int'(level_q) + int'(wadd) - int'(radd));
            wr_ptr_q <= PTR_W'(ring_add(int'(wr_ptr_q), wadd, DEPTH));
            rd_ptr_q <= PTR_W'(ring_add(int'(rd_ptr_q), radd, DEPTH));
            if (wr_go_o && wr_dual_i) right_q <= !right_q;
            if (rd_req_i && !rd_go_o) uf_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lim_q <= '0;
        else if (lim_we_i)
            lim_q <= (int'(lim_val_i) > DEPTH) ? LVL_W'(DEPTH) : lim_val_i;
    end

    assign wr_ptr_o     = wr_ptr_q;
    assign rd_ptr_o     = rd_ptr_q;
    assign level_o      = level_q;
    assign next_right_o = right_q;
    assign underflow_o  = uf_q;
    assign req_o        = (level_q < lim_q);
    assign empty_o      = (level_q < LVL_W'(2));
endmodule

// File: rtl/stx_slot_store.sv
module stx_slot_store
    import stx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_go_i,
    input  slot_pair_t               wr_pair_i,
    input  logic [$clog2(DEPTH)-1:0] wr_ptr_i,
    input  logic                     rd_go_i,
    input  logic [$clog2(DEPTH)-1:0] rd_ptr_i,
    output logic [SMP_W-1:0]         left_o,
    output logic [SMP_W-1:0]         right_o,
    output logic                     valid_o
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [SMP_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_b, rd_ptr_b;

    assign wr_ptr_b = PTR_W'(ring_add(int'(wr_ptr_i), 1, DEPTH));
    assign rd_ptr_b = PTR_W'(ring_add(int'(rd_ptr_i), 1, DEPTH));

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_go_i && PTR_W'(i) == wr_ptr_i)
                mem[i] <= wr_pair_i.first;
            else if (wr_go_i && wr_pair_i.two && PTR_W'(i) == wr_ptr_b)
                mem[i] <= wr_pair_i.second;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            left_o  <= '0;
            right_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= rd_go_i;
            if (rd_go_i) begin
                left_o  <= mem[rd_ptr_i];
                right_o <= mem[rd_ptr_b];
            end
        end
    end
endmodule

// File: rtl/stx_tx_fifo.sv
module stx_tx_fifo
    import stx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush_i,
    input  logic [1:0]       mode_i,
    input  logic             wr_en_i,
    input  logic [31:0]      wr_data_i,
    output logic             wr_ok_o,
    input  logic             lim_we_i,
    input  logic [LVL_W-1:0] lim_val_i,
    input  logic             pop_i,
    output logic [31:0]      pair_left_o,
    output logic [31:0]      pair_right_o,
    output logic             pair_valid_o,
    output logic             empty_o,
    output logic [LVL_W-1:0] level_o,
    output logic             mismatch_o,
    output logic             next_right_o,
    output logic             req_o,
    output logic             underflow_o
);
    localparam int PTR_W = $clog2(DEPTH);

    slot_pair_t       pair;
    logic             is_dual, wr_go, rd_go;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    stx_unpack u_unpack (
        .mode_i    (mode_i),
        .word_i    (wr_data_i),
        .pair_o    (pair),
        .is_dual_o (is_dual)
    );

    stx_level_ctl #(.DEPTH(DEPTH)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .flush_i      (flush_i),
        .wr_req_i     (wr_en_i),
        .wr_two_i     (pair.two),
        .wr_dual_i    (is_dual),
        .rd_req_i     (pop_i),
        .lim_we_i     (lim_we_i),
        .lim_val_i    (lim_val_i),
        .wr_go_o      (wr_go),
        .rd_go_o      (rd_go),
        .wr_ptr_o     (wr_ptr),
        .rd_ptr_o     (rd_ptr),
        .level_o      (level_o),
        .next_right_o (next_right_o),
        .underflow_o  (underflow_o),
        .req_o        (req_o),
        .empty_o      (empty_o)
    );

    stx_slot_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_go_i   (wr_go),
        .wr_pair_i (pair),
        .wr_ptr_i  (wr_ptr),
        .rd_go_i   (rd_go),
        .rd_ptr_i  (rd_ptr),
        .left_o    (pair_left_o),
        .right_o   (pair_right_o),
        .valid_o   (pair_valid_o)
    );

    assign wr_ok_o    = wr_go;
    assign mismatch_o = level_o[0];
endmodule

// File: rtl/stx_tx_fifo_chk.sv
module stx_tx_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH+1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_i,
    input logic [1:0]       mode_i,
    input logic             wr_en_i,
    input logic [31:0]      wr_data_i,
    input logic             wr_ok_o,
    input logic             lim_we_i,
    input logic [LVL_W-1:0] lim_val_i,
    input logic             pop_i,
    input logic [31:0]      pair_left_o,
    input logic [31:0]      pair_right_o,
    input logic             pair_valid_o,
    input logic             empty_o,
    input logic [LVL_W-1:0] level_o,
    input logic             mismatch_o,
    input logic             next_right_o,
    input logic             req_o,
    input logic             underflow_o
);
    // R1
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        int'(level_o) <= DEPTH);

    // R1
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(level_o) == DEPTH && !pop_i && !flush_i) |=> int'(level_o) == DEPTH);

    // R2
    dual_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok_o && mode_i == 2'd0 && !pop_i && !flush_i)
        |=> (level_o == $past(level_o) + 1'b1) && (next_right_o != $past(next_right_o)));

    // R5
    pair_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok_o && mode_i != 2'd0 && !pop_i && !flush_i)
        |=> (level_o == $past(level_o) + 2'd2) && $stable(next_right_o));

    // R6
    req_room_chk: assert property (@(posedge clk) disable iff (rst)
        req_o |-> int'(level_o) < DEPTH);

    // R8
    pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !flush_i && int'(level_o) >= 2) |=> pair_valid_o);

    // R9
    underrun_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !flush_i && int'(level_o) < 2) |=> underflow_o && !pair_valid_o);

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> level_o == '0 && !next_right_o && !underflow_o && !pair_valid_o);
endmodule

bind stx_tx_fifo stx_tx_fifo_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_stx_tx_fifo.sv
module tb_stx_tx_fifo;
    localparam int D = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        wr_ok_o;
    logic        lim_we_i = 1'b0;
    logic [4:0]  lim_val_i = '0;
    logic        pop_i = 1'b0;
    logic [31:0] pair_left_o, pair_right_o;
    logic        pair_valid_o, empty_o, mismatch_o, next_right_o, req_o, underflow_o;
    logic [4:0]  level_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] mq[$];
    int          mlim  = 0;
    bit          mright = 0;
    bit          muf   = 0;

    always #5 clk = ~clk;

    stx_tx_fifo dut (.*);

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_lim();
        return (mlim > D) ? D : mlim;
    endfunction

    task automatic check_state(string rtag);
        int lv;
        lv = mq.size();
        chk(int'(level_o) == lv, "R1 level", level_o, lv);
        chk(next_right_o == mright, "R2 phase", next_right_o, mright);
        chk(mismatch_o == lv[0], "R2 odd", mismatch_o, lv[0]);
        chk(empty_o == (lv < 2), "R10 empty", empty_o, lv < 2);
        chk(underflow_o == muf, "R9 flag", underflow_o, muf);
        chk(req_o == (lv < eff_lim()), rtag, req_o, lv < eff_lim());
    endtask

    function automatic void model_push(int m, logic [31:0] d);
        case (m)
            0: begin mq.push_back(d); mright = !mright; end
            1: begin mq.push_back({16'h0, d[15:0]}); mq.push_back({16'h0, d[31:16]}); end
            2: begin mq.push_back({24'h0, d[7:0]}); mq.push_back({24'h0, d[15:8]}); end
            default: begin mq.push_back(d); mq.push_back(d); end
        endcase
    endfunction

    function automatic bit fits(int m);
        return mq.size() + ((m == 0) ? 1 : 2) <= D;
    endfunction

    // All tasks start and end at a falling edge.
    task automatic wr(int m, logic [31:0] d, string rtag);
        bit eo;
        mode_i = 2'(m); wr_data_i = d; wr_en_i = 1'b1;
        eo = fits(m);
        #1;
        chk(wr_ok_o == eo, "R1 accept", wr_ok_o, eo);
        @(negedge clk);
        wr_en_i = 1'b0;
        if (eo) model_push(m, d);
        check_state(rtag);
    endtask

    task automatic pop(string tag);
        bit ev;
        logic [31:0] el, er;
        pop_i = 1'b1;
        ev = mq.size() >= 2;
        el = '0; er = '0;
        @(negedge clk);
        pop_i = 1'b0;
        if (ev) begin
            el = mq.pop_front(); er = mq.pop_front();
            chk(pair_left_o == el, tag, pair_left_o, el);
            chk(pair_right_o == er, tag, pair_right_o, er);
        end else begin
            muf = 1'b1;
        end
        chk(pair_valid_o == ev, ev ? "R8 valid" : "R9 valid", pair_valid_o, ev);
        check_state("R6");
        if (ev) begin
            @(negedge clk);
            chk(pair_valid_o == 1'b0, "R8 one cycle", pair_valid_o, 0);
        end
    endtask

    task automatic wr_pop(int m, logic [31:0] d);
        bit eo, ev;
        logic [31:0] el, er;
        mode_i = 2'(m); wr_data_i = d; wr_en_i = 1'b1; pop_i = 1'b1;
        eo = fits(m);
        ev = mq.size() >= 2;
        #1;
        chk(wr_ok_o == eo, "R12 accept", wr_ok_o, eo);
        @(negedge clk);
        wr_en_i = 1'b0; pop_i = 1'b0;
        if (ev) begin
            el = mq.pop_front(); er = mq.pop_front();
            chk(pair_left_o == el, "R12 left", pair_left_o, el);
            chk(pair_right_o == er, "R12 right", pair_right_o, er);
        end else muf = 1'b1;
        chk(pair_valid_o == ev, "R12 valid", pair_valid_o, ev);
        if (eo) model_push(m, d);
        check_state("R12");
    endtask

    task automatic flush(string tag);
        flush_i = 1'b1; wr_en_i = 1'b1; pop_i = 1'b1; mode_i = 2'd3; wr_data_i = 32'h1;
        #1;
        chk(wr_ok_o == 1'b0, tag, wr_ok_o, 0);
        @(negedge clk);
        flush_i = 1'b0; wr_en_i = 1'b0; pop_i = 1'b0;
        chk(pair_valid_o == 1'b0, tag, pair_valid_o, 0);
        mq.delete(); mright = 0; muf = 0;
        check_state("R11");
    endtask

    task automatic set_limit(int v);
        lim_we_i = 1'b1; lim_val_i = 5'(v);
        @(negedge clk);
        lim_we_i = 1'b0;
        mlim = v;
        check_state("R7");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_state("R7 reset");
        chk(pair_valid_o == 1'b0, "R8 reset", pair_valid_o, 0);

        // R2 dual alternation
        wr(0, 32'hAAAA_0001, "R6");
        wr(0, 32'hBBBB_0002, "R6");
        pop("R2 pair");
        // R3 compact 16
        wr(1, 32'hBEEF_1234, "R6");
        pop("R3 pack16");
        // R4 compact 8, upper bits ignored
        wr(2, 32'hFFFF_5A3C, "R6");
        wr(2, 32'h0000_5A3C, "R6");
        pop("R4 pack8");
        pop("R4 pack8");
        // R5 mono
        wr(3, 32'hC0DE_7788, "R6");
        pop("R5 mono");

        // R1 capacity
        for (int i = 0; i < D; i++) wr(0, 32'h100 + i, "R6");
        wr(0, 32'hDEAD, "R1 full");
        wr(3, 32'hDEAD, "R1 full");
        flush("R11 flush");
        for (int i = 0; i < D - 1; i++) wr(0, 32'h200 + i, "R6");
        wr(1, 32'hDEAD_DEAD, "R1 room");
        wr(2, 32'hDEAD_DEAD, "R1 room");
        for (int i = 0; i < 7; i++) pop("R8 order");
        pop("R9 odd underrun");
        flush("R11 flush");
        pop("R9 empty underrun");
        wr(3, 32'h55, "R6");
        chk(underflow_o == 1'b1, "R9 sticky", underflow_o, 1);
        flush("R11 flush");

        // R6 / R7 limit sweep
        for (int lim = 0; lim <= 20; lim++) begin
            set_limit(lim);
            flush("R11 flush");
            for (int k = 0; k < D; k++) wr(0, 32'h300 + k, "R6 R7 sweep");
        end
        set_limit(8);
        flush("R11 keeps limit");

        // Mixed modes
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 6; i++) wr(m, (32'h0101_0101 * (i + 1)) ^ (32'h1357_9BDF << m), "R6");
            while (mq.size() >= 2) pop("R8 mixed");
            flush("R11 flush");
        end

        // R12 simultaneous write and pop
        wr_pop(3, 32'h11);
        wr(1, 32'h2222_3333, "R6");
        wr_pop(0, 32'h44);
        wr_pop(0, 32'h55);
        wr_pop(2, 32'h0000_6677);
        for (int i = 0; i < 12; i++) wr(3, 32'h900 + i, "R6");
        wr_pop(1, 32'h8888_9999);
        while (mq.size() >= 2) pop("R12 drain");
        flush("R11 flush");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule